// File: doc/BRIEF.md
# Power-Good and Power-Down Controller

This block interprets one active-low board pin whose meaning changes over time. Right after power-on reset the pin acts as a power-good qualifier. While it stays low, the clock outputs are held off, but the oscillator and the serial control port keep running. The first clean high on the pin arms the block. From then until the next power-on reset, the same pin is a power-down request.

Once armed, a low level on the pin shuts everything down at once, without waiting for a clock edge. The output-allow signal, the oscillator enable and the serial-port enable all fall together. The shutdown is held in a flop that the pin sets asynchronously, so even a very short low pulse leads to a full standby.

Leaving standby is paced by the reference clock. The pin passes through a synchronizer. It must then read high for a set number of consecutive samples before the enables are raised again. The raise happens on a clock edge, so the clock gating logic downstream restarts cleanly. A two-bit mode output reports the current phase.

Top module: `pgpd_ctrl`

## Requirements
- R1: After reset, and for as long as the pin has never been qualified high, mode reads 2'b00, out_allow is 0, and osc_en and ser_en are 1, however long the pin stays low.
- R2: The first qualified high on the pin moves mode to 2'b01 with all three enables at 1. After that, mode never returns to 2'b00 until reset.
- R3: With mode at 2'b01, a low on the pin immediately drives out_allow, osc_en and ser_en to 0 and mode to 2'b10, with no clock edge needed.
- R4: While in standby (mode 2'b10), out_allow, osc_en and ser_en are all 0.
- R5: A low pulse shorter than one clock period, seen while active, still causes standby. The enables stay at 0 after the pin returns high, until a fresh qualified high.
- R6: With the default settings (two synchronizer stages, two qualifying samples), a pin rise that stays high gives mode 2'b01 on the fourth rising clock edge after the rise. After a sub-cycle low pulse, mode 2'b01 returns on the third edge after the pulse. Both restart latencies are at least two and at most six edges.
- R7: A high level that the synchronizer captures on only one sample does not move the block out of mode 2'b00 or 2'b10.
- R8: Reset returns the block to mode 2'b00 from any state, and the pin again acts as a power-good qualifier.
- R9: Mode never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| pwr_pin_n | input | 1 | Shared active-low power-good / power-down pin |
| out_allow | output | 1 | Permits the clock gating block to drive outputs |
| osc_en | output | 1 | Oscillator enable |
| ser_en | output | 1 | Serial control port enable |
| mode | output | 2 | 00 waiting for power-good, 01 active, 10 standby |

## Verification
The restart path and the asynchronous shutdown path can act in the same clock cycle. This happens when the qualifier completes its run of high samples on the same edge at which the pin has just fallen again. The bench provokes it by raising the pin out of standby and pulling it low in the half cycle before the fourth edge. Correct behaviour is that out_allow never shows a 1 and the mode reads standby on that edge and the next. A sub-cycle low pulse while active is also applied, and the bench checks that the shutdown holds after the pulse ends.

// File: rtl/pgpd_pkg.sv
package pgpd_pkg;
  typedef enum logic [1:0] {
    PG_WAIT  = 2'b00,
    PG_RUN   = 2'b01,
    PG_SLEEP = 2'b10
  } pg_mode_e;
endpackage

// File: rtl/pgpd_sync.sv
// Multi-stage level synchronizer for the shared pin; clears to "low" on reset.
module pgpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgpd_qual.sv
// Counts consecutive high synchronized samples; valid on the SAMPLES-th one.
module pgpd_qual #(
  parameter int SAMPLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic lvl,
  output logic valid
);
  localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !lvl) run_cnt <= '0;
    else if (run_cnt != LAST) run_cnt <= run_cnt + 1'b1;
  end

  assign valid = lvl && (run_cnt == LAST) && !clr;
endmodule

// File: rtl/pgpd_fsm.sv
// Mode sequencer plus the asynchronously set shutdown flop.
module pgpd_fsm
  import pgpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_n,
  input  logic       valid,
  output logic       kill,
  output logic       out_allow,
  output logic       osc_en,
  output logic       ser_en,
  output logic [1:0] mode
);
  pg_mode_e state_q, state_d;
  logic     drop_q;

  // Shutdown request: set by the raw pin without a clock, cleared only
  // on the edge that re-enters the active state.
  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n)                             drop_q <= 1'b1;
    else if (rst)                           drop_q <= 1'b0;
    else if ((state_q != PG_RUN) && valid)  drop_q <= 1'b0;
  end

  assign kill = (state_q == PG_RUN) && drop_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PG_WAIT:  if (valid) state_d = PG_RUN;
      PG_RUN:   if (drop_q) state_d = PG_SLEEP;
      PG_SLEEP: if (valid) state_d = PG_RUN;
      default:  state_d = PG_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PG_WAIT;
    else     state_q <= state_d;
  end

  assign out_allow = (state_q == PG_RUN) && !drop_q;
  assign osc_en    = (state_q == PG_WAIT) || out_allow;
  assign ser_en    = (state_q == PG_WAIT) || out_allow;
  assign mode      = kill ? PG_SLEEP : state_q;
endmodule

// File: rtl/pgpd_ctrl.sv
module pgpd_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_pin_n,
  output logic       out_allow,
  output logic       osc_en,
  output logic       ser_en,
  output logic [1:0] mode
);
  logic pin_s;
  logic rise_ok;
  logic kill;

  pgpd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwr_pin_n),
    .q   (pin_s)
  );

  pgpd_qual #(.SAMPLES(QUAL_SAMPLES)) i_qual (
    .clk   (clk),
    .rst   (rst),
    .clr   (kill),
    .lvl   (pin_s),
    .valid (rise_ok)
  );

  pgpd_fsm i_fsm (
    .clk       (clk),
    .rst       (rst),
    .pin_n     (pwr_pin_n),
    .valid     (rise_ok),
    .kill      (kill),
    .out_allow (out_allow),
    .osc_en    (osc_en),
    .ser_en    (ser_en),
    .mode      (mode)
  );
endmodule

// File: rtl/pgpd_chk.sv
module pgpd_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_pin_n,
  input logic       out_allow,
  input logic       osc_en,
  input logic       ser_en,
  input logic [1:0] mode
);
  // R1
  assert_wait_keeps_osc_R1: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> (osc_en && ser_en && !out_allow));

  // R2
  assert_run_all_on_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (out_allow && osc_en && ser_en));

  // R2
  assert_no_rewait_R2: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b00) |=> (mode != 2'b00));

  // R3
  assert_pin_low_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    ((mode != 2'b00) && !pwr_pin_n) |-> (!out_allow && !osc_en && !ser_en));

  // R4
  assert_sleep_all_off_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> (!out_allow && !osc_en && !ser_en));

  // R8
  assert_reset_to_wait_R8: assert property (@(posedge clk)
    $past(rst) |-> (mode == 2'b00));

  // R9
  assert_mode_legal_R9: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b11);
endmodule

bind pgpd_ctrl pgpd_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_pin_n (pwr_pin_n),
  .out_allow (out_allow),
  .osc_en    (osc_en),
  .ser_en    (ser_en),
  .mode      (mode)
);

// File: tb/test_pgpd_ctrl.sv
module test_pgpd_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic       out_allow, osc_en, ser_en;
  logic [1:0] mode;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #10 clk = ~clk;

  pgpd_ctrl i_pgpd_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pwr_pin_n (pin),
    .out_allow (out_allow),
    .osc_en    (osc_en),
    .ser_en    (ser_en),
    .mode      (mode)
  );

  // {mode, out_allow, osc_en, ser_en}
  localparam logic [4:0] S_WAIT  = 5'b00_011;
  localparam logic [4:0] S_RUN   = 5'b01_111;
  localparam logic [4:0] S_SLEEP = 5'b10_000;

  // {pin, cycles[3:0], expected {mode, out, osc, ser}}
  localparam logic [9:0] VEC [0:8] = '{
    10'b0_0101_00_011,  // R1: low pin while waiting keeps osc/ser up
    10'b1_0011_00_011,  // R6: three edges after rise, still waiting
    10'b1_0001_01_111,  // R2 R6: fourth edge arms and activates
    10'b1_0110_01_111,  // R2: stays active
    10'b0_0001_10_000,  // R3 R4: low enters standby
    10'b0_1000_10_000,  // R4: held in standby
    10'b1_0011_10_000,  // R6: not yet restarted
    10'b1_0001_01_111,  // R6: restart on fourth edge
    10'b0_0010_10_000   // R2: armed pin gives standby, not waiting
  };

  function automatic logic [4:0] obs();
    return {mode, out_allow, osc_en, ser_en};
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // Reset with the pin low
    edges(3);
    @(negedge clk) rst = 1'b0;
    edges(1);
    chk("R1 reset state", obs(), S_WAIT);

    // Vector walk
    for (int v = 0; v < 9; v++) begin
      @(negedge clk) pin = VEC[v][9];
      edges(int'(VEC[v][8:5]));
      chk($sformatf("vector %0d (R1 R2 R3 R4 R6)", v), obs(), VEC[v][4:0]);
    end

    // R7: one-sample high while in standby is ignored
    @(negedge clk) pin = 1'b1;
    @(negedge clk) pin = 1'b0;
    edges(6);
    chk("R7 standby short high", obs(), S_SLEEP);

    // Back to active
    @(negedge clk) pin = 1'b1;
    edges(4);
    chk("R6 restart", obs(), S_RUN);

    // R3 and R5: sub-cycle low pulse, observed between edges
    @(negedge clk);
    #3 pin = 1'b0;
    #1 chk("R3 immediate shutdown", obs(), S_SLEEP);
    #1 pin = 1'b1;
    #1 chk("R5 held after pulse", obs(), S_SLEEP);
    edges(1);
    chk("R5 standby after pulse edge", obs(), S_SLEEP);
    edges(1);
    chk("R6 no restart after two edges", obs(), S_SLEEP);
    edges(1);
    chk("R6 restart on third edge after pulse", obs(), S_RUN);

    // Collision: restart qualifies on the same edge the pin falls again
    @(negedge clk) pin = 1'b0;
    edges(4);
    @(negedge clk) pin = 1'b1;
    edges(3);
    chk("R6 collision pre", obs(), S_SLEEP);
    @(negedge clk) pin = 1'b0;
    edges(1);
    chk("R3 collision edge", obs(), S_SLEEP);
    edges(1);
    chk("R4 collision after", obs(), S_SLEEP);

    // R8: reset from standby returns to waiting
    @(negedge clk) rst = 1'b1;
    edges(2);
    @(negedge clk) rst = 1'b0;
    edges(1);
    chk("R8 reset from standby", obs(), S_WAIT);

    // R7: one-sample high while waiting is ignored
    @(negedge clk) pin = 1'b1;
    @(negedge clk) pin = 1'b0;
    edges(6);
    chk("R7 waiting short high", obs(), S_WAIT);

    // R1: long low while waiting
    edges(10);
    chk("R1 long low wait", obs(), S_WAIT);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule